// File: doc/BRIEF.md
# GPIO Bank Data and Direction Registers

This block is the data path of one bank of general-purpose pins. Software reaches it through a single-cycle register request port. It can set each pin to input or output and write the value that output pins drive. It can read back the synchronized levels on the pins. It also provides a fixed identification word. Two write-only addresses change chosen bits of the output latch in one write, so no read-modify-write sequence is needed.

Each pin has three wires. `pin_in` carries the sampled level. `pin_out` carries the latched drive value. `pin_oe` is the driver enable for the pad. The direction register is active-low for output: a 1 makes the pin an input. `pin_oe` is therefore the bitwise inverse of that register.

A small two-state machine handles reads.
- `BUS_IDLE` to `BUS_RESP` (accept): a read is accepted.
- `BUS_RESP` to `BUS_RESP` (chain): another read arrives straight after the first.
- `BUS_RESP` to `BUS_IDLE` (drain): no read arrives.
- `BUS_IDLE` to `BUS_IDLE` (wait): no read arrives.

The response word is valid while the machine is in `BUS_RESP`. Writes take effect at the clock edge that accepts them and produce no response.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, `pin_out` is 0 and `pin_oe` is 0. The direction register (byte offset 0x134) reads 0xFFFFFFFF, meaning every pin is an input. The output latch (offset 0x13C) reads 0.
- R2: Offset 0x000 reads 0x50600801 at all times. Writes to it have no effect.
- R3: A write to offset 0x134 loads the direction register, where bit p belongs to pin p. From the next cycle, `pin_oe` equals the bitwise inverse of the written word, and a read of 0x134 returns that word.
- R4: A write to offset 0x13C loads the output latch. From the next cycle, `pin_out` equals the written word, and a read of 0x13C returns it.
- R5: A write to offset 0x194 sets every latch bit that is 1 in the data and leaves the bits that are 0 unchanged. The offset reads as 0.
- R6: A write to offset 0x190 clears every latch bit that is 1 in the data and leaves the bits that are 0 unchanged. The offset reads as 0.
- R7: A read of offset 0x138 returns `pin_in` after a two-flop synchronizer. A pin level held for two clock edges is visible to a read accepted at the third edge. Writes to 0x138 have no effect.
- R8: A read of any other offset returns 0. A write to any other offset changes neither the pins nor any register.
- R9: Each accepted read (`req_valid`=1, `req_write`=0) raises `rsp_valid` for exactly the next cycle, with `rsp_rdata` holding the register value as it stood when the read was accepted. Back-to-back reads give back-to-back responses. A cycle without a read gives `rsp_valid`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch value to the pads |
| pin_oe | output | 32 | Output driver enable, 1 = drive |

## Verification
The properties assume that a request lasts exactly one cycle, with address, data and direction held throughout that cycle. They also assume that `req_write` and `req_addr` are meaningful only while `req_valid` is high. The bench drives every request between clock edges and holds it for one full cycle. It lowers `req_valid` between operations unless it is deliberately issuing back-to-back reads. It changes `pin_in` only when no read of the input register is due for at least two edges, so the synchronizer latency never makes an expected value ambiguous.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_IDENT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h134;
    localparam logic [ADDR_W-1:0] OFF_DIN   = 12'h138;
    localparam logic [ADDR_W-1:0] OFF_DOUT  = 12'h13C;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h190;
    localparam logic [ADDR_W-1:0] OFF_SET   = 12'h194;

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h5060_0801;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic dir_we;
        logic dout_we;
        logic set_we;
        logic clr_we;
    } wr_strobe_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  dir_q,
    input  logic [NPINS-1:0]  dout_q,
    input  logic [NPINS-1:0]  din_q,
    output wr_strobe_t        strb,
    output logic [DATA_W-1:0] rd_value
);
    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (addr)
                OFF_DIR:  strb.dir_we  = 1'b1;
                OFF_DOUT: strb.dout_we = 1'b1;
                OFF_SET:  strb.set_we  = 1'b1;
                OFF_CLR:  strb.clr_we  = 1'b1;
                default:  strb = '0;
            endcase
        end
    end

    always_comb begin
        rd_value = '0;
        case (addr)
            OFF_IDENT: rd_value = IDENT_WORD;
            OFF_DIR:   rd_value[NPINS-1:0] = dir_q;
            OFF_DIN:   rd_value[NPINS-1:0] = din_q;
            OFF_DOUT:  rd_value[NPINS-1:0] = dout_q;
            default:   rd_value = '0;
        endcase
    end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       strb,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] dout_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '1;
        else if (strb.dir_we) dir_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            dout_q <= '0;
        else if (strb.dout_we) dout_q <= wdata;
        else if (strb.set_we)  dout_q <= dout_q | wdata;
        else if (strb.clr_we)  dout_q <= dout_q & ~wdata;
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_value;
    end

    assign rsp_valid = (state_q == BUS_RESP);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    wr_strobe_t        strb;
    logic [NPINS-1:0]  dir_q, dout_q, din_q;
    logic [DATA_W-1:0] rd_value;

    gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(din_q)
    );

    gpio_reg_decode #(.NPINS(NPINS)) i_dec (
        .wr_en(req_valid && req_write), .addr(req_addr),
        .dir_q(dir_q), .dout_q(dout_q), .din_q(din_q),
        .strb(strb), .rd_value(rd_value)
    );

    gpio_out_regs #(.NPINS(NPINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .strb(strb),
        .wdata(req_wdata[NPINS-1:0]), .dir_q(dir_q), .dout_q(dout_q)
    );

    gpio_bus_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .rd_req(req_valid && !req_write),
        .rd_value(rd_value), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);
    // R1
    initial_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 || !rst_n));

    // R2
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFF_IDENT) |=> rsp_rdata == IDENT_WORD);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_DIR) |=> pin_oe == ~$past(req_wdata[NPINS-1:0]));

    // R4
    dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_DOUT) |=> pin_out == $past(req_wdata[NPINS-1:0]));

    // R5
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_SET) |=>
        pin_out == ($past(pin_out) | $past(req_wdata[NPINS-1:0])));

    // R6
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFF_CLR) |=>
        pin_out == ($past(pin_out) & ~$past(req_wdata[NPINS-1:0])));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NPINS(NPINS)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Driver: called at a negedge; holds the request for one cycle.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        exp_item_t it;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the expected item for every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk("R9 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk(it.req, rsp_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        do_read(12'h134, 32'hFFFF_FFFF, "R1 dir reset");
        do_read(12'h13C, 32'h0, "R1 dout reset");
        // R2 identification word
        do_read(12'h000, 32'h5060_0801, "R2 ident");
        idle(1);

        // R3 direction
        do_write(12'h134, 32'h0000_00FF);
        chk("R3 pin_oe", pin_oe, 32'hFFFF_FF00);
        do_read(12'h134, 32'h0000_00FF, "R3 dir readback");
        idle(1);

        // R4 output latch
        do_write(12'h13C, 32'hA5A5_0000);
        chk("R4 pin_out", pin_out, 32'hA5A5_0000);
        do_read(12'h13C, 32'hA5A5_0000, "R4 dout readback");
        idle(1);

        // R5 set
        do_write(12'h194, 32'h0000_000F);
        chk("R5 pin_out after set", pin_out, 32'hA5A5_000F);
        do_read(12'h194, 32'h0, "R5 set reads zero");
        idle(1);

        // R6 clear
        do_write(12'h190, 32'hA000_0003);
        chk("R6 pin_out after clear", pin_out, 32'h05A5_000C);
        do_read(12'h190, 32'h0, "R6 clear reads zero");
        idle(1);

        // R2 ident write ignored
        do_write(12'h000, 32'h0);
        do_read(12'h000, 32'h5060_0801, "R2 ident after write");
        idle(1);

        // R8 unmapped offsets
        do_write(12'h200, 32'hFFFF_FFFF);
        chk("R8 pin_out unchanged", pin_out, 32'h05A5_000C);
        chk("R8 pin_oe unchanged", pin_oe, 32'hFFFF_FF00);
        do_read(12'h200, 32'h0, "R8 unmapped read");
        idle(1);

        // R7 synchronized input
        pin_in = 32'h1234_5678;
        idle(2);
        do_read(12'h138, 32'h1234_5678, "R7 din");
        do_write(12'h138, 32'hFFFF_FFFF);
        chk("R7 pin_out after din write", pin_out, 32'h05A5_000C);
        do_read(12'h138, 32'h1234_5678, "R7 din after write");
        idle(1);
        pin_in = 32'hCAFE_0001;
        idle(2);
        do_read(12'h138, 32'hCAFE_0001, "R7 din second pattern");
        idle(1);

        // R9 back-to-back reads, then no response after a write
        do_read(12'h000, 32'h5060_0801, "R9 b2b first");
        do_read(12'h13C, 32'h05A5_000C, "R9 b2b second");
        do_read(12'h134, 32'h0000_00FF, "R9 b2b third");
        do_write(12'h13C, 32'h0000_0001);
        chk("R9 no response after write", {31'b0, rsp_valid}, 32'h0);
        idle(2);
        chk("R9 all responses received", sb_q.size(), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule